// File: doc/BRIEF.md
# Write-Once Nonvolatile Memory Clock Divider

This block sets the timebase for the timing engine of a nonvolatile memory. Software programs one 8-bit configuration register over a simple register port, which has a write strobe, write data and read data. The register holds a divisor and a prescale select. The block then divides the bus clock and issues a single-cycle tick once per period of the slow memory clock. The erase and program sequencer counts these ticks to form its timing pulses.

The configuration accepts one write after reset and ignores all later writes. That first write also sets a loaded flag, whatever data it carries. The flag is bit 7 of the register and also drives the output that permits erase and program operations. Until the flag is set, the divider is held at zero and issues no ticks.

The divider has two stages. The first is an optional divide-by-8 prescaler. The second is a counter that divides by the divisor field plus one.

Top module: `nvm_clkdiv`

## Requirements
- R1: After reset, `rd_data` reads 0x00, and `tick` and `pgm_enable` are both 0.
- R2: The first write after reset sets `rd_data[7]` (the loaded flag), even when the write data is 0x00.
- R3: On the first write, `rd_data[6]` takes `wr_data[6]` (1 selects the divide-by-8 prescale) and `rd_data[5:0]` takes `wr_data[5:0]` (the divisor DIV). `wr_data[7]` has no effect.
- R4: Once the loaded flag is set, every later write leaves `rd_data` unchanged and does not disturb the tick phase.
- R5: `pgm_enable` is 1 exactly when the loaded flag is set.
- R6: While the loaded flag is 0, `tick` stays 0.
- R7: With prescale 0, `tick` pulses for one cycle every DIV+1 bus cycles. Cycle 0 is the first cycle after the clock edge that took the write. The first pulse comes in cycle DIV.
- R8: With prescale 1, `tick` pulses for one cycle every 8×(DIV+1) bus cycles. The first pulse comes in cycle 8×(DIV+1)−1.
- R9: With DIV=0 and prescale 0, `tick` is high on every cycle once loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data: {loaded, prescale, DIV} |
| tick | output | 1 | One-cycle pulse at the divided memory-clock rate |
| pgm_enable | output | 1 | Erase and program permitted |

## Verification
The divider is exercised with five settings, each after a fresh reset:
- DIV=0 without prescale. This separates a tick on every cycle from a tick that is stuck high or missing.
- A mid-range DIV without prescale.
- A small DIV with prescale.
- DIV=0 with prescale. This isolates the prescaler period on its own.
- The largest DIV without prescale. This exposes truncation of the counter.

Each case predicts the exact cycle of the first tick and of the following ones, so an off-by-one in either stage shows as a miscompare. One case writes the register a second time partway through its run, to show that the register contents and the tick phase are both unaffected. Another case writes all zeros, to show that the loaded flag does not depend on the data.

// File: rtl/nvm_clkdiv_pkg.sv
package nvm_clkdiv_pkg;
    localparam int DIV_W     = 6;
    localparam int PRE_RATIO = 8;
    localparam int REG_W     = DIV_W + 2;
    localparam int PRE_W     = $clog2(PRE_RATIO);

    typedef struct packed {
        logic             loaded;
        logic             pre8;
        logic [DIV_W-1:0] div;
    } cfg_t;
endpackage

// File: rtl/nvm_clkdiv_cfg.sv
module nvm_clkdiv_cfg
    import nvm_clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output cfg_t             cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && !cfg_q.loaded) begin
            cfg_d.loaded = 1'b1;
            cfg_d.pre8   = wr_data[DIV_W];
            cfg_d.div    = wr_data[DIV_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/nvm_clkdiv_pre.sv
module nvm_clkdiv_pre
    import nvm_clkdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic pre8,
    output logic stb
);
    localparam logic [PRE_W-1:0] LAST = PRE_W'(PRE_RATIO - 1);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run || !pre8)          st_d.cnt = '0;
        else if (st_q.cnt == LAST)  st_d.cnt = '0;
        else                        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stb = run && (!pre8 || (st_q.cnt == LAST));
endmodule

// File: rtl/nvm_clkdiv_cnt.sv
module nvm_clkdiv_cnt
    import nvm_clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             stb,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    at_end;

    assign at_end = (st_q.cnt == div);

    always_comb begin
        st_d = st_q;
        if (!run)        st_d.cnt = '0;
        else if (stb)    st_d.cnt = at_end ? '0 : st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = run && stb && at_end;
endmodule

// File: rtl/nvm_clkdiv.sv
module nvm_clkdiv
    import nvm_clkdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       tick,
    output logic       pgm_enable
);
    cfg_t cfg;
    logic pre_stb;

    nvm_clkdiv_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    nvm_clkdiv_pre u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cfg.loaded),
        .pre8  (cfg.pre8),
        .stb   (pre_stb)
    );

    nvm_clkdiv_cnt u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cfg.loaded),
        .stb   (pre_stb),
        .div   (cfg.div),
        .tick  (tick)
    );

    assign rd_data    = cfg;
    assign pgm_enable = cfg.loaded;
endmodule

// File: rtl/nvm_clkdiv_chk.sv
module nvm_clkdiv_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] rd_data,
    input logic       tick,
    input logic       pgm_enable
);
    AST_FIRST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_data[7]) |=> rd_data[7]); // R2
    AST_LOCKED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7] |=> $stable(rd_data)); // R4
    AST_ENABLE_RISES_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgm_enable) |-> $past(wr_en)); // R5
    AST_NO_TICK_UNLOADED: assert property (@(posedge clk) disable iff (!rst_n)
        !pgm_enable |-> !tick); // R6
    AST_DIV0_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] && rd_data[6:0] == 7'd0) |-> tick); // R9
endmodule

bind nvm_clkdiv nvm_clkdiv_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_data    (rd_data),
    .tick       (tick),
    .pgm_enable (pgm_enable)
);

// File: tb/test_nvm_clkdiv.sv
module test_nvm_clkdiv;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       tick;
    logic       pgm_enable;

    int    n_vec  = 0;
    int    n_fail = 0;
    int    k      = 0;
    bit    mon_on = 1'b0;
    string cur_req = "R7";
    int    exp_q[$];

    always #10 clk = ~clk;

    nvm_clkdiv i_nvm_clkdiv (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .tick       (tick),
        .pgm_enable (pgm_enable)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected tick cycles and compares
    always @(negedge clk) begin
        if (mon_on) begin
            if (tick) begin
                if (exp_q.size() == 0) chk(cur_req, k, -1);
                else                   chk(cur_req, k, exp_q.pop_front());
            end
            k++;
        end
    end

    task automatic run_case(input logic pre, input logic [5:0] div,
                            input logic [7:0] data, input bit second_wr);
        int per;
        per = (div + 1) * (pre ? 8 : 1);
        cur_req = pre ? "R8" : ((div == 0) ? "R9" : "R7");
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
        chk("R1", rd_data, 0);
        chk("R1", {tick, pgm_enable}, 0);
        for (int i = 0; i < 5; i++) begin
            @(posedge clk);
            #2 chk("R6", tick, 0);
        end
        // driver: push expected tick cycles
        for (int i = 1; i <= 4; i++) exp_q.push_back(i * per - 1);
        wr_en = 1'b1;
        wr_data = data;
        @(posedge clk);
        #2 wr_en = 1'b0;
        k = 0;
        mon_on = 1'b1;
        chk("R2", rd_data[7], 1);
        chk("R3", rd_data[6:0], {pre, div});
        chk("R5", pgm_enable, 1);
        if (second_wr) begin
            repeat (2 * per) @(posedge clk);
            #2 wr_en = 1'b1;
            wr_data = ~data;
            @(posedge clk);
            #2 wr_en = 1'b0;
            chk("R4", rd_data, {1'b1, pre, div});
            repeat (2 * per - 1) @(posedge clk);
        end else begin
            repeat (4 * per) @(posedge clk);
        end
        #2 mon_on = 1'b0;
        chk(cur_req, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        run_case(1'b0, 6'd0,  8'h00, 1'b0);
        run_case(1'b0, 6'd5,  8'h05, 1'b1);
        run_case(1'b1, 6'd2,  8'hC2, 1'b0);
        run_case(1'b1, 6'd0,  8'h40, 1'b0);
        run_case(1'b0, 6'd63, 8'h3F, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule